// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Override

This block is an 8-bit general-purpose I/O port reached through a small register interface. Software sets each pin's direction, writes the value driven on output pins, and reads the pad levels. A separate read-only view returns the sampled pad levels for every pin, outputs included, so a driven pin that is overloaded or shorted shows a level different from the one written.

A peripheral-enable input hands the lower seven pins to an external media-independent interface. While it is high, those pins are forced to inputs whatever the direction bits hold, and the topmost pin stays under software control. The stored direction bits are kept through the override and take effect again as soon as the enable drops. Pad levels cross a two-flop synchronizer on the bus clock before they are read, so a level change needs two clock edges to become visible.

Top module: `gpio_port`

## Requirements
- R1: During and right after reset, the direction and output data registers are all zero: pad_oe is 8'h00, pad_out is 8'h00 and the direction address reads 8'h00.
- R2: Address 2'd2 is the direction register, readable and writable at any time; a bit of 1 makes that pin an output. A write takes effect on pad_oe (for pins not under override) at the same clock edge that stores it.
- R3: Address 2'd0 holds the output data register; a write stores bus_wdata, and pad_out equals the stored value from the next cycle on, whatever the direction.
- R4: Address 2'd1 reads the pad levels through a two-flop synchronizer: the value returned equals pad_in as sampled two clock edges earlier, for every pin including outputs.
- R5: Writes to address 2'd1 or 2'd3 change neither the direction nor the output data register.
- R6: While mii_en is 1, pad_oe[6:0] are 0 regardless of the direction bits; pad_oe[7] still equals direction bit 7.
- R7: The direction bits are kept unchanged through an override; when mii_en returns to 0, pad_oe equals the direction register again in the same cycle.
- R8: A read of address 2'd0 returns, per bit, the output data bit when that pin is currently driven (pad_oe bit 1), and the synchronized pad level otherwise.
- R9: A read of address 2'd3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state and the synchronizer run on it |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 data, 1 pad levels, 2 direction, 3 unused |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| mii_en | input | 1 | Forces pins 6 to 0 to inputs while high |
| pad_in | input | 8 | Levels seen at the pads |
| pad_out | output | 8 | Values to drive at the pads |
| pad_oe | output | 8 | Per-pin output enable, 1 drives the pad |

## Verification
A corrupted direction bit appears on pad_oe in the cycle after the faulty write, unless the override hides it, in which case it reappears the moment mii_en falls. A corrupted data bit shows on pad_out one cycle after the write and on the data readback only for driven pins. A synchronizer of the wrong depth shows up as pin readback that is one edge early or late after any pad change, which random pad toggling exposes within a few cycles.

// File: rtl/gpio_pkg.sv
// Package: shared address map and widths for the GPIO port.
// Assumes a 2-bit register select on the bus.
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        GP_DATA = 2'd0,
        GP_PIN  = 2'd1,
        GP_DIR  = 2'd2,
        GP_RSVD = 2'd3
    } gp_addr_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Two-stage synchronizer for pad inputs on the bus clock.
// Assumes pad inputs are asynchronous and each bit may be sampled on its own.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift chain: first stage samples the pad, later stages follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Holds the direction and output data registers and applies write rules.
// Assumes one write per cycle; writes to the pin and unused addresses are dropped.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  data_q
);
    gp_addr_e sel;
    assign sel = gp_addr_e'(wr_addr);

    // Direction register: written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dir_q <= '0;
        else if (wr_en && sel == GP_DIR) dir_q <= wr_data;
    end

    // Output data register: written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)                       data_q <= '0;
        else if (wr_en && sel == GP_DATA) data_q <= wr_data;
    end
endmodule

// File: rtl/gpio_override.sv
// Module: gpio_override
// Computes per-pin output enables, masking pins claimed by the peripheral.
// Assumes OVR_MASK marks the pins the peripheral forces to inputs.
module gpio_override #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] OVR_MASK = 8'h7F
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic             periph_en,
    output logic [WIDTH-1:0] oe
);
    // Per-pin variant chosen at elaboration: overridable or software-only.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (OVR_MASK[i]) begin : g_ovr
            assign oe[i] = dir_q[i] & ~periph_en;
        end else begin : g_sw
            assign oe[i] = dir_q[i];
        end
    end
endmodule

// File: rtl/gpio_readmux.sv
// Module: gpio_readmux
// Selects read data for the addressed register.
// Assumes driven pins return the latched value on the data address.
module gpio_readmux
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  data_q,
    input  logic [WIDTH-1:0]  oe,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  rd_data
);
    // Address decode for the read path.
    always_comb begin
        unique case (gp_addr_e'(rd_addr))
            GP_DATA: rd_data = (oe & data_q) | (~oe & pin_sync);
            GP_PIN:  rd_data = pin_sync;
            GP_DIR:  rd_data = dir_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
// Module: gpio_port (top)
// 8-pin GPIO port with direction/data/pin registers and a peripheral
// override on the low pins. Assumes a single bus clock and synchronous
// active-low reset; pad inputs are asynchronous.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] OVR_MASK = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              mii_en,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    localparam int SYNC_STAGES = 2;

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] oe;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (bus_addr),
        .wr_en   (bus_we),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    gpio_override #(.WIDTH(WIDTH), .OVR_MASK(OVR_MASK)) u_ovr (
        .dir_q     (dir_q),
        .periph_en (mii_en),
        .oe        (oe)
    );

    gpio_readmux #(.WIDTH(WIDTH)) u_rd (
        .rd_addr  (bus_addr),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .oe       (oe),
        .pin_sync (pin_sync),
        .rd_data  (bus_rdata)
    );

    assign pad_out = data_q;
    assign pad_oe  = oe;
endmodule

// File: rtl/gpio_port_chk.sv
// Module: gpio_port_chk
// Port-level temporal checks for gpio_port, attached by bind.
// Assumes the default mask (pins 6..0 overridable, pin 7 software-only).
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] OVR_MASK = 8'h7F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              mii_en,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe
);
    logic [1:0] warm_q;

    // Counts edges since reset release, saturating, to gate history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    AST_OVR_FORCES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        mii_en |-> ((pad_oe & OVR_MASK) == '0)); // R6

    AST_DIR_WRITE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == GP_DIR) |=> (pad_oe[WIDTH-1] == $past(bus_wdata[WIDTH-1]))); // R2

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == GP_DATA) |=> (pad_out == $past(bus_wdata))); // R3

    AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == GP_PIN || bus_addr == GP_RSVD))
        |=> ($stable(pad_out) && $stable(pad_oe[WIDTH-1]))); // R5

    AST_PIN_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q[1] && bus_addr == GP_PIN) |-> (bus_rdata == $past(pad_in, 2))); // R4

    AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == GP_RSVD) |-> (bus_rdata == '0)); // R9
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .OVR_MASK(OVR_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mii_en    (mii_en),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_port_tb_top.sv
// Bench: random register traffic and pad activity against a requirement model.
module gpio_port_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 8;
    localparam logic [W-1:0] MASK = 8'h7F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         mii_en = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Requirement model state
    logic [W-1:0] m_dir = '0, m_data = '0, m_s1 = '0, m_s2 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mii_en(mii_en),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [W-1:0] exp_oe(logic [W-1:0] dir, logic ovr);
        return dir & ~(ovr ? MASK : '0);
    endfunction

    function automatic logic [W-1:0] exp_rd(logic [1:0] a, logic [W-1:0] dir,
                                            logic [W-1:0] dat, logic [W-1:0] s,
                                            logic ovr);
        logic [W-1:0] oe = exp_oe(dir, ovr);
        case (a)
            2'd0:    return (oe & dat) | (~oe & s);
            2'd1:    return s;
            2'd2:    return dir;
            default: return '0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check before the edge, update model after it.
    task automatic step(logic [1:0] a, logic we, logic [W-1:0] wd, logic ovr,
                        logic [W-1:0] pin, string tag);
        string rtag;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; mii_en = ovr; pad_in = pin;
        #1;
        if (tag != "") rtag = tag;
        else case (a)
            2'd0: rtag = "R8";
            2'd1: rtag = "R4";
            2'd2: rtag = "R2";
            default: rtag = "R9";
        endcase
        check(rtag, "bus_rdata", bus_rdata, exp_rd(a, m_dir, m_data, m_s2, ovr));
        check(ovr ? "R6" : "R2", "pad_oe", pad_oe, exp_oe(m_dir, ovr));
        check("R3", "pad_out", pad_out, m_data);
        @(posedge clk);
        if (we && a == 2'd0) m_data = wd;
        if (we && a == 2'd2) m_dir = wd;
        m_s2 = m_s1;
        m_s1 = pin;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // Reset with noisy pads and attempted writes
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pad_in = W'($urandom); bus_addr = 2'd2; bus_we = 1'b1; bus_wdata = 8'hFF;
        end
        #1;
        check("R1", "dir read in reset", bus_rdata, 8'h00);
        check("R1", "pad_oe in reset", pad_oe, 8'h00);
        check("R1", "pad_out in reset", pad_out, 8'h00);
        @(negedge clk);
        bus_we = 1'b0; pad_in = '0; rst_n = 1'b1;
        step(2'd2, 1'b0, 8'h00, 1'b0, 8'h00, "R1");
        step(2'd0, 1'b0, 8'h00, 1'b0, 8'h00, "R1");

        // Directed: all outputs, data pattern, pins shorted to opposite values
        step(2'd2, 1'b1, 8'hFF, 1'b0, 8'h00, "R2");
        step(2'd0, 1'b1, 8'hA5, 1'b0, 8'h5A, "R3");
        step(2'd1, 1'b0, 8'h00, 1'b0, 8'h5A, "R4");
        step(2'd1, 1'b0, 8'h00, 1'b0, 8'h5A, "R4");
        step(2'd0, 1'b0, 8'h00, 1'b0, 8'h5A, "R8");

        // Directed: writes to pin and unused addresses are dropped
        step(2'd1, 1'b1, 8'h00, 1'b0, 8'h5A, "R5");
        step(2'd3, 1'b1, 8'h00, 1'b0, 8'h5A, "R9");
        step(2'd2, 1'b0, 8'h00, 1'b0, 8'h5A, "R5");
        step(2'd0, 1'b0, 8'h00, 1'b0, 8'h5A, "R5");

        // Directed: override on, direction kept, override off restores
        step(2'd0, 1'b0, 8'h00, 1'b1, 8'h3C, "R6");
        step(2'd2, 1'b0, 8'h00, 1'b1, 8'h3C, "R7");
        step(2'd0, 1'b0, 8'h00, 1'b1, 8'h3C, "R8");
        step(2'd2, 1'b1, 8'h0F, 1'b1, 8'h3C, "R7");
        step(2'd2, 1'b0, 8'h00, 1'b1, 8'h3C, "R7");
        step(2'd2, 1'b0, 8'h00, 1'b0, 8'h3C, "R7");
        step(2'd0, 1'b0, 8'h00, 1'b0, 8'h3C, "R8");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]   a   = 2'($urandom);
            logic         we  = ($urandom % 3) != 0;
            logic [W-1:0] wd  = W'($urandom);
            logic         ovr = ($urandom % 4) == 0;
            logic [W-1:0] pin = (($urandom % 2) == 0) ? pad_in : W'($urandom);
            step(a, we, wd, ovr, pin, "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule